// File: doc/BRIEF.md
# PWM Event-Trigger Prescaler

This block watches the running value of a PWM time-base counter together with its period and two compare values, and turns chosen counter events into trigger pulses. It has three channels: channel 0 raises an interrupt request, channels 1 and 2 start analog-to-digital conversions (A and B). Each channel picks its own event source, can be enabled or disabled, and divides its events by a programmable ratio of 1, 2 or 3 before it fires.

Every channel shows a 2-bit count of the events seen since its last pulse, and a sticky flag that a pulse sets and software clears. The interrupt channel will not fire again while its flag is still set. The conversion channels fire whether or not their flag is set. The counter, the action logic that drives the PWM pins and the register decode all live outside this block. The block only receives the register fields as plain inputs.

Top module: `etr_prescaler`

## Requirements
- R1: The 3-bit event select of a channel decodes as follows. 3'b001 is counter == 0. 3'b010 is counter == period. 3'b100 is counter == compare A while counting up. 3'b101 is counter == compare A while counting down. 3'b110 is counter == compare B while counting up. 3'b111 is counter == compare B while counting down. `count_up` = 1 means counting up.
- R2: Select codes 3'b000 and 3'b011 never produce an event, so the count does not move and no pulse is produced.
- R3: An event is taken once per match, in the first cycle the selected equality holds. A counter that stays on the matching value produces no further events.
- R4: A period select of 2'b00 turns the channel's divider off. Its count does not advance and it never pulses.
- R5: With period select N (1 to 3) and the channel enabled and not blocked, the Nth event produces a pulse and the count returns to 0. Before that, `trig_count` shows 0 to N-1.
- R6: `trig_pulse` is registered, so it is high for exactly the cycle after the clock edge that took the firing event. The channel's flag is set in that same cycle.
- R7: The conversion channels (1 and 2) fire even when their flag is still set from an earlier pulse.
- R8: The interrupt channel (0) does not fire while its flag is set. Its count advances up to the period select and holds there. The first selected event after the flag is cleared fires it.
- R9: A flag stays set until `ch_flag_clr` is sampled high, and it reads 0 in the following cycle. If a clear and a pulse land on the same edge, the flag stays set.
- R10: A channel with its enable at 0 never pulses. Its count still advances on events and stops at the period select.
- R11: Synchronous reset clears every count, flag and pulse to 0.
- R12: If the period select is lowered to or below the current count, no pulse comes at once. The next selected event produces the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tb_count | input | CNT_W | Time-base counter value |
| tb_period | input | CNT_W | Time-base period value |
| cmp_a | input | CNT_W | Compare A value |
| cmp_b | input | CNT_W | Compare B value |
| count_up | input | 1 | 1 = counter is incrementing, 0 = decrementing |
| ch_sel | input | 3x3 | Event select per channel (index 0 interrupt, 1 conversion A, 2 conversion B) |
| ch_en | input | 3 | Pulse enable per channel |
| ch_period | input | 3x2 | Events per pulse per channel, 0 = off |
| ch_flag_clr | input | 3 | Flag clear per channel, acts on the next edge |
| trig_pulse | output | 3 | One-cycle trigger pulse per channel |
| trig_flag | output | 3 | Sticky flag per channel |
| trig_count | output | 3x2 | Events seen since the last pulse, per channel |

## Verification
The main stimulus sweeps the counter up from zero to the period and back down, under several mixes of selects, so that direction-qualified compare matches can be told apart from plain zero and period matches. A counter held still on a matching value separates edge-taken events from level-taken ones. Runs with no flag clear and with clears landing on the firing edge show how the interrupt channel is blocked while the conversion channels are not. A period select lowered under a pending count shows that a pulse comes only on the next event and never at the moment of the write.

// File: rtl/etr_pkg.sv
package etr_pkg;

    localparam int NCH   = 3;
    localparam int SEL_W = 3;
    localparam int PRD_W = 2;

    // channel roles; index order is fixed by the top module
    localparam int CH_IRQ  = 0;
    localparam int CH_CNVA = 1;
    localparam int CH_CNVB = 2;

    typedef enum logic [SEL_W-1:0] {
        EV_NONE0   = 3'b000,
        EV_ZERO    = 3'b001,
        EV_PERIOD  = 3'b010,
        EV_NONE3   = 3'b011,
        EV_CA_UP   = 3'b100,
        EV_CA_DOWN = 3'b101,
        EV_CB_UP   = 3'b110,
        EV_CB_DOWN = 3'b111
    } ev_sel_e;

    typedef struct packed {
        logic               eq_zero;
        logic               eq_period;
        logic               eq_ca;
        logic               eq_cb;
        logic               up;
    } tb_cmp_t;

    typedef struct packed {
        ev_sel_e            sel;
        logic               en;
        logic [PRD_W-1:0]   period;
        logic               clr;
    } ch_cfg_t;

    typedef struct packed {
        logic [PRD_W-1:0]   count;
        logic               flag;
        logic               pulse;
    } ch_state_t;

    function automatic logic sel_match(ev_sel_e s, tb_cmp_t c);
        logic m;
        unique case (s)
            EV_ZERO:    m = c.eq_zero;
            EV_PERIOD:  m = c.eq_period;
            EV_CA_UP:   m = c.eq_ca &  c.up;
            EV_CA_DOWN: m = c.eq_ca & ~c.up;
            EV_CB_UP:   m = c.eq_cb &  c.up;
            EV_CB_DOWN: m = c.eq_cb & ~c.up;
            default:    m = 1'b0;
        endcase
        return m;
    endfunction

    // count after an event that did not fire: saturates at the period select
    function automatic logic [PRD_W-1:0] count_step(logic [PRD_W-1:0] cnt,
                                                    logic [PRD_W-1:0] prd);
        return (cnt < prd) ? cnt + 1'b1 : cnt;
    endfunction

    // the event that arrives now is the one that completes the division
    function automatic logic reaches(logic [PRD_W-1:0] cnt,
                                     logic [PRD_W-1:0] prd);
        return ({1'b0, cnt} + 1'b1) >= {1'b0, prd};
    endfunction

endpackage

// File: rtl/etr_tb_compare.sv
module etr_tb_compare
    import etr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] tb_count,
    input  logic [CNT_W-1:0] tb_period,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic             count_up,
    output tb_cmp_t          cmp
);
    // shared equality comparators, fanned out to every channel
    always_comb begin
        cmp.eq_zero   = (tb_count == '0);
        cmp.eq_period = (tb_count == tb_period);
        cmp.eq_ca     = (tb_count == cmp_a);
        cmp.eq_cb     = (tb_count == cmp_b);
        cmp.up        = count_up;
    end
endmodule

// File: rtl/etr_event_src.sv
module etr_event_src
    import etr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  tb_cmp_t cmp,
    input  ev_sel_e sel,
    output logic    event_o
);
    logic match_now;
    logic match_q;

    always_comb begin
        match_now = sel_match(sel, cmp);
        event_o   = match_now & ~match_q;
    end

    always_ff @(posedge clk) begin
        if (rst) match_q <= 1'b0;
        else     match_q <= match_now;
    end
endmodule

// File: rtl/etr_chan_ctr.sv
module etr_chan_ctr
    import etr_pkg::*;
#(
    parameter bit BLOCK_ON_FLAG = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      event_i,
    input  ch_cfg_t   cfg,
    output ch_state_t st
);
    ch_state_t st_q;
    ch_state_t st_d;
    logic      active;
    logic      gate;
    logic      fire;

    always_comb begin
        active = event_i && (cfg.period != '0);
        gate   = cfg.en && !(BLOCK_ON_FLAG && st_q.flag);
        fire   = active && gate && reaches(st_q.count, cfg.period);

        st_d = st_q;
        if (fire)
            st_d.count = '0;
        else if (active)
            st_d.count = count_step(st_q.count, cfg.period);
        st_d.pulse = fire;
        st_d.flag  = fire | (st_q.flag & ~cfg.clr);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/etr_prescaler.sv
module etr_prescaler
    import etr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [CNT_W-1:0]           tb_count,
    input  logic [CNT_W-1:0]           tb_period,
    input  logic [CNT_W-1:0]           cmp_a,
    input  logic [CNT_W-1:0]           cmp_b,
    input  logic                       count_up,
    input  logic [NCH-1:0][SEL_W-1:0]  ch_sel,
    input  logic [NCH-1:0]             ch_en,
    input  logic [NCH-1:0][PRD_W-1:0]  ch_period,
    input  logic [NCH-1:0]             ch_flag_clr,
    output logic [NCH-1:0]             trig_pulse,
    output logic [NCH-1:0]             trig_flag,
    output logic [NCH-1:0][PRD_W-1:0]  trig_count
);
    tb_cmp_t cmp;

    etr_tb_compare #(.CNT_W(CNT_W)) u_cmp (
        .tb_count  (tb_count),
        .tb_period (tb_period),
        .cmp_a     (cmp_a),
        .cmp_b     (cmp_b),
        .count_up  (count_up),
        .cmp       (cmp)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ch_cfg_t   cfg;
        ch_state_t st;
        logic      ev;

        always_comb begin
            cfg.sel    = ev_sel_e'(ch_sel[i]);
            cfg.en     = ch_en[i];
            cfg.period = ch_period[i];
            cfg.clr    = ch_flag_clr[i];
        end

        etr_event_src u_src (
            .clk     (clk),
            .rst     (rst),
            .cmp     (cmp),
            .sel     (cfg.sel),
            .event_o (ev)
        );

        // only the interrupt channel is held off by its own flag
        etr_chan_ctr #(.BLOCK_ON_FLAG(i == CH_IRQ)) u_ctr (
            .clk     (clk),
            .rst     (rst),
            .event_i (ev),
            .cfg     (cfg),
            .st      (st)
        );

        assign trig_pulse[i] = st.pulse;
        assign trig_flag[i]  = st.flag;
        assign trig_count[i] = st.count;
    end
endmodule

// File: rtl/etr_prescaler_chk.sv
module etr_prescaler_chk
    import etr_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic [NCH-1:0][SEL_W-1:0]  ch_sel,
    input logic [NCH-1:0]             ch_en,
    input logic [NCH-1:0][PRD_W-1:0]  ch_period,
    input logic [NCH-1:0]             ch_flag_clr,
    input logic [NCH-1:0]             trig_pulse,
    input logic [NCH-1:0]             trig_flag,
    input logic [NCH-1:0][PRD_W-1:0]  trig_count
);
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (rst)
            (ch_sel[i] == 3'b000 || ch_sel[i] == 3'b011) |=> !trig_pulse[i]); // R2
        AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
            (ch_period[i] == '0) |=> !trig_pulse[i]); // R4
        AST_PULSE_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
            trig_pulse[i] |-> (trig_count[i] == '0)); // R5
        AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
            trig_pulse[i] |-> trig_flag[i]); // R6
        AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
            (trig_flag[i] && !ch_flag_clr[i]) |=> trig_flag[i]); // R9
        AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
            ch_flag_clr[i] |=> (trig_pulse[i] || !trig_flag[i])); // R9
        AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
            !ch_en[i] |=> !trig_pulse[i]); // R10
    end

    AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        trig_flag[CH_IRQ] |=> !trig_pulse[CH_IRQ]); // R8
endmodule

bind etr_prescaler etr_prescaler_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ch_sel      (ch_sel),
    .ch_en       (ch_en),
    .ch_period   (ch_period),
    .ch_flag_clr (ch_flag_clr),
    .trig_pulse  (trig_pulse),
    .trig_flag   (trig_flag),
    .trig_count  (trig_count)
);

// File: tb/sim_etr_prescaler.sv
`timescale 1ns/1ps
module sim_etr_prescaler;
    import etr_pkg::*;

    localparam int CNT_W = 16;
    localparam int PER   = 10;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic [CNT_W-1:0]          tb_count = '0;
    logic [CNT_W-1:0]          tb_period = CNT_W'(PER);
    logic [CNT_W-1:0]          cmp_a = 16'd4;
    logic [CNT_W-1:0]          cmp_b = 16'd7;
    logic                      count_up = 1'b1;
    logic [NCH-1:0][SEL_W-1:0] ch_sel = '0;
    logic [NCH-1:0]            ch_en = '0;
    logic [NCH-1:0][PRD_W-1:0] ch_period = '0;
    logic [NCH-1:0]            ch_flag_clr = '0;
    logic [NCH-1:0]            trig_pulse;
    logic [NCH-1:0]            trig_flag;
    logic [NCH-1:0][PRD_W-1:0] trig_count;

    always #4 clk = ~clk;

    etr_prescaler #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .tb_count(tb_count), .tb_period(tb_period),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .count_up(count_up),
        .ch_sel(ch_sel), .ch_en(ch_en), .ch_period(ch_period),
        .ch_flag_clr(ch_flag_clr), .trig_pulse(trig_pulse),
        .trig_flag(trig_flag), .trig_count(trig_count)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req  = "R11";
    bit    done     = 0;

    // reference model state
    int m_cnt[NCH];
    int m_flag[NCH];
    int m_pulse[NCH];
    int m_prev[NCH];
    int seen[NCH];

    function automatic int hit(int s);
        int v = int'(tb_count);
        case (s)
            1: return v == 0;
            2: return v == int'(tb_period);
            4: return (v == int'(cmp_a)) && count_up;
            5: return (v == int'(cmp_a)) && !count_up;
            6: return (v == int'(cmp_b)) && count_up;
            7: return (v == int'(cmp_b)) && !count_up;
            default: return 0;
        endcase
    endfunction

    task automatic model_edge();
        for (int i = 0; i < NCH; i++) begin
            if (rst) begin
                m_cnt[i] = 0; m_flag[i] = 0; m_pulse[i] = 0; m_prev[i] = 0;
            end else begin
                int m = hit(int'(ch_sel[i]));
                int ev = m && !m_prev[i];
                int p = int'(ch_period[i]);
                int f = 0;
                m_prev[i] = m;
                if (ev && p > 0) begin
                    if (m_cnt[i] + 1 >= p && ch_en[i] && !(i == 0 && m_flag[i])) begin
                        f = 1; m_cnt[i] = 0;
                    end else if (m_cnt[i] < p) begin
                        m_cnt[i]++;
                    end
                end
                m_pulse[i] = f;
                if (f) m_flag[i] = 1;
                else if (ch_flag_clr[i]) m_flag[i] = 0;
            end
        end
    endtask

    task automatic chk(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        for (int i = 0; i < NCH; i++) begin
            chk($sformatf("pulse[%0d]", i), int'(trig_pulse[i]), m_pulse[i]);
            chk($sformatf("flag[%0d]", i),  int'(trig_flag[i]),  m_flag[i]);
            chk($sformatf("count[%0d]", i), int'(trig_count[i]), m_cnt[i]);
            if (trig_pulse[i]) seen[i]++;
        end
    endtask

    task automatic put(int v, bit up);
        tb_count = CNT_W'(v);
        count_up = up;
        tick();
    endtask

    task automatic sweep(int n);
        for (int k = 0; k < n; k++) begin
            for (int v = 0; v <= PER; v++) put(v, 1'b1);
            for (int v = PER - 1; v >= 1; v--) put(v, 1'b0);
        end
    endtask

    task automatic clear_seen();
        for (int i = 0; i < NCH; i++) seen[i] = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_errors++;
            $display("FAIL %s watchdog expired actual=hung expected=finished", cur_req);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cur_req = "R11";
        do_reset();
        chk("reset state", int'({trig_pulse, trig_flag, trig_count}), 0);

        // R1 / R5: direction-qualified matches and division by 1
        cur_req = "R1";
        ch_sel = {3'b100, 3'b010, 3'b001};
        ch_en = '1;
        ch_period = {2'b01, 2'b01, 2'b01};
        ch_flag_clr = '1;
        clear_seen();
        sweep(2);
        chk("CNVB compare-A up pulses", seen[2], 2);
        ch_sel = {3'b111, 3'b110, 3'b101};
        clear_seen();
        sweep(2);
        chk("IRQ compare-A down pulses", seen[0], 2);

        cur_req = "R5";
        ch_period = {2'b11, 2'b10, 2'b01};
        ch_sel = {3'b001, 3'b001, 3'b001};
        clear_seen();
        sweep(6);
        chk("CNVA divide-by-2 pulses", seen[1], 3);
        chk("CNVB divide-by-3 pulses", seen[2], 2);

        cur_req = "R6";
        ch_flag_clr = '0;
        for (int k = 0; k < 4; k++) begin
            ch_flag_clr = (k % 2) ? 3'b111 : 3'b000;
            sweep(1);
        end

        cur_req = "R2";
        do_reset();
        ch_sel = {3'b011, 3'b000, 3'b011};
        ch_period = {2'b01, 2'b01, 2'b01};
        ch_en = '1;
        clear_seen();
        sweep(2);
        chk("reserved pulses", seen[0] + seen[1] + seen[2], 0);
        chk("reserved counts", int'(trig_count), 0);

        cur_req = "R4";
        ch_sel = {3'b001, 3'b010, 3'b001};
        ch_period = '0;
        clear_seen();
        sweep(2);
        chk("off pulses", seen[0] + seen[1] + seen[2], 0);
        chk("off counts", int'(trig_count), 0);

        cur_req = "R3";
        ch_sel[0] = 3'b001;
        ch_period[0] = 2'b01;
        ch_flag_clr = 3'b001;
        put(5, 1'b1);
        ch_flag_clr = '0;
        clear_seen();
        for (int k = 0; k < 10; k++) put(0, 1'b1);
        chk("held counter IRQ pulses", seen[0], 1);

        cur_req = "R8";
        clear_seen();
        sweep(2);
        chk("blocked IRQ pulses", seen[0], 0);
        chk("blocked IRQ count", int'(trig_count[0]), 1);
        ch_flag_clr = 3'b001;
        put(5, 1'b1);
        ch_flag_clr = '0;
        chk("IRQ flag cleared", int'(trig_flag[0]), 0);
        put(0, 1'b1);
        chk("IRQ fires after clear", int'(trig_pulse[0]), 1);

        cur_req = "R7";
        ch_sel[1] = 3'b010;
        ch_period[1] = 2'b01;
        ch_en[1] = 1'b1;
        clear_seen();
        sweep(3);
        chk("CNVA pulses with flag set", seen[1], 3);
        chk("CNVA flag still set", int'(trig_flag[1]), 1);

        cur_req = "R9";
        ch_sel[1] = 3'b001;
        put(5, 1'b1);
        ch_flag_clr = 3'b010;
        put(0, 1'b1);
        chk("clear loses to pulse: pulse", int'(trig_pulse[1]), 1);
        chk("clear loses to pulse: flag", int'(trig_flag[1]), 1);
        put(5, 1'b1);
        ch_flag_clr = '0;
        chk("clear alone", int'(trig_flag[1]), 0);

        cur_req = "R10";
        do_reset();
        ch_sel = {3'b001, 3'b001, 3'b001};
        ch_period = {2'b10, 2'b10, 2'b10};
        ch_en = '0;
        clear_seen();
        sweep(3);
        chk("disabled pulses", seen[0] + seen[1] + seen[2], 0);
        chk("disabled count saturates", int'(trig_count[2]), 2);

        cur_req = "R12";
        do_reset();
        ch_sel[2] = 3'b001;
        ch_en = '1;
        ch_period = {2'b11, 2'b00, 2'b00};
        put(5, 1'b1); put(0, 1'b1); put(5, 1'b1); put(0, 1'b1);
        chk("count before rewrite", int'(trig_count[2]), 2);
        ch_period[2] = 2'b01;
        put(5, 1'b1);
        chk("no pulse on rewrite", int'(trig_pulse[2]), 0);
        put(0, 1'b1);
        chk("pulse on next event", int'(trig_pulse[2]), 1);
        chk("count back to zero", int'(trig_count[2]), 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule